// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a 32-bit host register port reach a bank of internal 32-bit control/status registers. The bank is addressed with 16 bits, so the host cannot map it directly. The host sees two words. The first is a command word: it holds the target address, the direction, the stepping controls, a busy flag and a sticky error flag. The second is a data word: it holds write data before an access and read data after one.

The bridge forwards each access to the bank over a request/acknowledge handshake. The bank may take any number of cycles to answer. Software polls the busy flag until it reads 0. Sequential reads can step the address by one upward or downward, with wrap-around. In that mode, each host read of the data word starts the next bank read. The bridge also has a direct write window: a host write into the window's address range starts a bank write at once, with no command write.

The sequencer has two states. ST_IDLE goes to ST_ACCESS on one of three start events:
- a command write with the busy bit set,
- a window write,
- a stepping data read.

ST_ACCESS holds the request and goes back to ST_IDLE on the acknowledge.

Top module: `csr_bridge`

## Requirements
- R1: After reset, the command word and data word read 0, and bank_req is low.
- R2: Host offset 0 is the command word and offset 1 is the data word. Offsets with host_addr[HOST_AW-1]=1 form the window, and every other offset reads 0. Command word fields are: busy at bit 31, read-not-write at bit 30, step-up at bit 29, step-down at bit 28, sticky error at bit 27, and address at bits 15:0. While idle, a command write with bit 31 set starts an access at the written address. With bit 31 clear, the write only loads the fields.
- R3: bank_req rises in the cycle after the start event. bank_addr and bank_we stay stable until bank_ack. Busy reads 0 from the cycle after bank_ack. For a read, the data word then holds bank_rdata.
- R4: For a write, the host writes the data word and then a command with bit 30 clear. The bank then sees bank_we=1 with the data word on bank_wdata.
- R5: While idle, with bit 30, step-up and not step-down set, a host read of the data word does three things: it returns the current data, adds 1 to the address, and starts a bank read in the next cycle. With the step bits cleared, the same read starts nothing.
- R6: With step-down and not step-up set, a data read subtracts 1 from the address instead and starts the next read in the same way.
- R7: With both step bits set, an access is a single access, and a data read neither steps the address nor starts a read.
- R8: Stepping wraps modulo 2^16: 16'hFFFF steps up to 16'h0000, and 16'h0000 steps down to 16'hFFFF.
- R9: While idle, a host write into the window does three things: it loads the data word, sets the address to the zero-extended low HOST_AW-1 offset bits, and starts a bank write with busy set.
- R10: While busy, any host write to the command word, data word or window is ignored and sets the error bit. This includes a write in the acknowledge cycle. The error bit stays set until a command write while idle with bit 27 set.
- R11: While busy, a host read of the data word has no side effect on the address or on the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | HOST_AW | Host word offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| bank_req | output | 1 | Bank access request, held until bank_ack |
| bank_we | output | 1 | Bank access is a write |
| bank_addr | output | FAB_AW | Bank register address |
| bank_wdata | output | 32 | Bank write data |
| bank_rdata | input | 32 | Bank read data, valid with bank_ack |
| bank_ack | input | 1 | Bank completion pulse |

## Verification
The corner case is a host write and a bank acknowledge landing in the same cycle. In that cycle the sequencer is about to return to idle, but the write must still count as arriving while busy. The bench waits until its bank model raises the acknowledge and drives a data-word write in that same cycle. It then expects the data word to keep the value of the completed access and the error bit to read 1. A second case puts a data-word read inside an access: the scoreboard must see exactly one bank read, and the address must not have stepped.

// File: rtl/csr_bridge_pkg.sv
package csr_bridge_pkg;
    localparam int CSR_DW   = 32;
    localparam int BIT_BUSY = 31;
    localparam int BIT_RNW  = 30;
    localparam int BIT_UP   = 29;
    localparam int BIT_DOWN = 28;
    localparam int BIT_ERR  = 27;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_ACCESS
    } seq_state_e;

    typedef struct packed {
        logic cmd_wr;
        logic data_wr;
        logic win_wr;
        logic data_rd;
    } host_ev_t;
endpackage

// File: rtl/csr_host_decode.sv
module csr_host_decode
    import csr_bridge_pkg::*;
#(
    parameter int HOST_AW = 10,
    localparam int WIN_AW = HOST_AW - 1
) (
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    output host_ev_t           ev,
    output logic               sel_cmd,
    output logic               sel_data,
    output logic [WIN_AW-1:0]  win_off
);
    logic in_win;

    always_comb begin
        in_win     = host_addr[HOST_AW-1];
        win_off    = host_addr[WIN_AW-1:0];
        sel_cmd    = !in_win && (win_off == WIN_AW'(0));
        sel_data   = !in_win && (win_off == WIN_AW'(1));
        ev.cmd_wr  = host_wr && sel_cmd;
        ev.data_wr = host_wr && sel_data;
        ev.win_wr  = host_wr && in_win;
        ev.data_rd = host_rd && !host_wr && sel_data;
    end
endmodule

// File: rtl/csr_addr_step.sv
module csr_addr_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic          up,
    input  logic          down,
    output logic [AW-1:0] nxt,
    output logic          stepping
);
    always_comb begin
        stepping = up ^ down;
        if (up && !down) begin
            nxt = addr + AW'(1);
        end else if (down && !up) begin
            nxt = addr - AW'(1);
        end else begin
            nxt = addr;
        end
    end
endmodule

// File: rtl/csr_seq_fsm.sv
module csr_seq_fsm
    import csr_bridge_pkg::*;
#(
    parameter int FAB_AW = 16,
    parameter int WIN_AW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  host_ev_t          ev,
    input  logic [CSR_DW-1:0] wdata,
    input  logic [WIN_AW-1:0] win_off,
    input  logic [FAB_AW-1:0] step_addr,
    input  logic              stepping,
    input  logic              bank_ack,
    input  logic [CSR_DW-1:0] bank_rdata,
    output logic              busy,
    output logic              bank_req,
    output logic              bank_we,
    output logic [FAB_AW-1:0] addr_q,
    output logic              rnw_q,
    output logic              up_q,
    output logic              down_q,
    output logic              err_q,
    output logic [CSR_DW-1:0] data_q
);
    seq_state_e st, st_nx;
    logic       go_cmd, go_step, start, any_wr;

    always_comb begin
        go_cmd  = ev.cmd_wr && wdata[BIT_BUSY];
        go_step = ev.data_rd && rnw_q && stepping;
        start   = go_cmd || ev.win_wr || go_step;
        any_wr  = ev.cmd_wr || ev.data_wr || ev.win_wr;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (start)    st_nx = ST_ACCESS;
            ST_ACCESS: if (bank_ack) st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // outputs
    always_comb begin
        busy     = (st == ST_ACCESS);
        bank_req = busy;
        bank_we  = busy && !rnw_q;
    end

    // command and data holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rnw_q  <= 1'b0;
            up_q   <= 1'b0;
            down_q <= 1'b0;
            err_q  <= 1'b0;
            data_q <= '0;
        end else if (st == ST_IDLE) begin
            if (ev.cmd_wr) begin
                addr_q <= wdata[FAB_AW-1:0];
                rnw_q  <= wdata[BIT_RNW];
                up_q   <= wdata[BIT_UP];
                down_q <= wdata[BIT_DOWN];
                if (wdata[BIT_ERR]) err_q <= 1'b0;
            end else if (ev.data_wr) begin
                data_q <= wdata;
            end else if (ev.win_wr) begin
                data_q <= wdata;
                addr_q <= FAB_AW'(win_off);
                rnw_q  <= 1'b0;
            end else if (go_step) begin
                addr_q <= step_addr;
            end
        end else begin
            if (any_wr) err_q <= 1'b1;
            if (bank_ack && rnw_q) data_q <= bank_rdata;
        end
    end
endmodule

// File: rtl/csr_bridge.sv
module csr_bridge
    import csr_bridge_pkg::*;
#(
    parameter int HOST_AW = 10,
    parameter int FAB_AW  = 16,
    localparam int WIN_AW = HOST_AW - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               bank_req,
    output logic               bank_we,
    output logic [FAB_AW-1:0]  bank_addr,
    output logic [31:0]        bank_wdata,
    input  logic [31:0]        bank_rdata,
    input  logic               bank_ack
);
    host_ev_t          ev;
    logic              sel_cmd, sel_data;
    logic [WIN_AW-1:0] win_off;
    logic [FAB_AW-1:0] addr_q, step_addr;
    logic              stepping, busy, rnw_q, up_q, down_q, err_flag;
    logic [CSR_DW-1:0] data_q;

    csr_host_decode #(.HOST_AW(HOST_AW)) u_dec (
        .host_wr  (host_wr),
        .host_rd  (host_rd),
        .host_addr(host_addr),
        .ev       (ev),
        .sel_cmd  (sel_cmd),
        .sel_data (sel_data),
        .win_off  (win_off)
    );

    csr_addr_step #(.AW(FAB_AW)) u_step (
        .addr    (addr_q),
        .up      (up_q),
        .down    (down_q),
        .nxt     (step_addr),
        .stepping(stepping)
    );

    csr_seq_fsm #(.FAB_AW(FAB_AW), .WIN_AW(WIN_AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .wdata     (host_wdata),
        .win_off   (win_off),
        .step_addr (step_addr),
        .stepping  (stepping),
        .bank_ack  (bank_ack),
        .bank_rdata(bank_rdata),
        .busy      (busy),
        .bank_req  (bank_req),
        .bank_we   (bank_we),
        .addr_q    (addr_q),
        .rnw_q     (rnw_q),
        .up_q      (up_q),
        .down_q    (down_q),
        .err_q     (err_flag),
        .data_q    (data_q)
    );

    always_comb begin
        bank_addr  = addr_q;
        bank_wdata = data_q;
        host_rdata = '0;
        if (sel_cmd) begin
            host_rdata[BIT_BUSY]     = busy;
            host_rdata[BIT_RNW]      = rnw_q;
            host_rdata[BIT_UP]       = up_q;
            host_rdata[BIT_DOWN]     = down_q;
            host_rdata[BIT_ERR]      = err_flag;
            host_rdata[FAB_AW-1:0]   = addr_q;
        end else if (sel_data) begin
            host_rdata = data_q;
        end
    end
endmodule

// File: rtl/csr_bridge_chk.sv
module csr_bridge_chk #(
    parameter int HOST_AW = 10,
    parameter int FAB_AW  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr,
    input logic [HOST_AW-1:0] host_addr,
    input logic               wd_go,
    input logic               wd_rnw,
    input logic               wd_errclr,
    input logic [FAB_AW-1:0]  wd_addr,
    input logic               busy,
    input logic               err,
    input logic               bank_req,
    input logic               bank_we,
    input logic               bank_ack,
    input logic [FAB_AW-1:0]  bank_addr
);
    logic is_win, is_cmd, is_data;
    assign is_win  = host_addr[HOST_AW-1];
    assign is_cmd  = (host_addr == HOST_AW'(0));
    assign is_data = (host_addr == HOST_AW'(1));

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bank_req && !bank_ack |=> bank_req && $stable(bank_addr) && $stable(bank_we)); // R3
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        bank_req && bank_ack |=> !busy); // R3
    AST_CMD_START: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && host_wr && is_cmd && wd_go |=>
        bank_req && bank_addr == $past(wd_addr) && bank_we == !$past(wd_rnw)); // R2
    AST_WIN_START: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && host_wr && is_win |=>
        bank_req && bank_we &&
        bank_addr == {{(FAB_AW-HOST_AW+1){1'b0}}, $past(host_addr[HOST_AW-2:0])}); // R9
    AST_BUSY_WR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        busy && host_wr && (is_cmd || is_data || is_win) |=> err); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err && !(host_wr && is_cmd && !busy && wd_errclr) |=> err); // R10
endmodule

bind csr_bridge csr_bridge_chk #(.HOST_AW(HOST_AW), .FAB_AW(FAB_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_wr  (host_wr),
    .host_addr(host_addr),
    .wd_go    (host_wdata[31]),
    .wd_rnw   (host_wdata[30]),
    .wd_errclr(host_wdata[27]),
    .wd_addr  (host_wdata[FAB_AW-1:0]),
    .busy     (busy),
    .err      (err_flag),
    .bank_req (bank_req),
    .bank_we  (bank_we),
    .bank_ack (bank_ack),
    .bank_addr(bank_addr)
);

// File: tb/test_csr_bridge.sv
module test_csr_bridge;
    localparam int HOST_AW = 10;
    localparam int FAB_AW  = 16;
    localparam logic [HOST_AW-1:0] A_CMD = 0, A_DATA = 1;

    logic clk = 0, rst_n = 0;
    logic host_wr = 0, host_rd = 0;
    logic [HOST_AW-1:0] host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic bank_req, bank_we, bank_ack = 0;
    logic [FAB_AW-1:0] bank_addr;
    logic [31:0] bank_wdata, bank_rdata = '0;

    int checks = 0, fails = 0, lat = 3, cnt = 0;
    logic [48:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    csr_bridge #(.HOST_AW(HOST_AW), .FAB_AW(FAB_AW)) i_csr_bridge (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .bank_req(bank_req), .bank_we(bank_we), .bank_addr(bank_addr),
        .bank_wdata(bank_wdata), .bank_rdata(bank_rdata), .bank_ack(bank_ack));

    function automatic logic [31:0] f(logic [15:0] a);
        return {a ^ 16'h5A5A, a};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic push(logic we, logic [15:0] a, logic [31:0] d, string tag);
        exp_q.push_back({we, a, d});
        tag_q.push_back(tag);
    endtask

    // bank model and scoreboard monitor
    always @(negedge clk) begin
        if (bank_ack) begin
            bank_ack <= 1'b0;
            cnt      <= 0;
        end else if (bank_req) begin
            if (cnt + 1 >= lat) begin
                logic [48:0] e;
                string t;
                bank_ack   <= 1'b1;
                bank_rdata <= f(bank_addr);
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R3 unexpected access act=%h exp=none", {bank_we, bank_addr});
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (bank_we !== e[48] || bank_addr !== e[47:32] ||
                        (e[48] && bank_wdata !== e[31:0])) begin
                        fails++;
                        $display("FAIL %s act=%h exp=%h", t,
                                 {bank_we, bank_addr, bank_wdata}, e);
                    end
                end
            end
            cnt <= cnt + 1;
        end
    end

    task automatic hwrite(logic [HOST_AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic hread(logic [HOST_AW-1:0] a, output logic [31:0] v);
        @(negedge clk);
        host_rd = 1; host_addr = a;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 40; i++) begin
            hread(A_CMD, v);
            if (!v[31]) break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R3 act=hang exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        hread(A_CMD, v);  chk("R1 cmd", v, 0);
        hread(A_DATA, v); chk("R1 data", v, 0);
        chk("R1 req", {31'd0, bank_req}, 0);

        // R2 field-only write
        hwrite(A_CMD, 32'h0000_0055);
        chk("R2 no start", {31'd0, bank_req}, 0);
        hread(A_CMD, v); chk("R2 fields", v, 32'h0000_0055);
        hread(2, v); chk("R2 unmapped", v, 0);

        // R3 single read
        push(0, 16'h1234, 0, "R3 read");
        hwrite(A_CMD, 32'hC000_1234);
        chk("R3 req next cycle", {31'd0, bank_req}, 1);
        wait_idle();
        hread(A_CMD, v);  chk("R3 cmd idle", v, 32'h4000_1234);
        hread(A_DATA, v); chk("R3 data", v, f(16'h1234));

        // R4 single write, latency 1
        lat = 1;
        hwrite(A_DATA, 32'hDEAD_BEEF);
        push(1, 16'h0042, 32'hDEAD_BEEF, "R4 write");
        hwrite(A_CMD, 32'h8000_0042);
        chk("R4 we", {31'd0, bank_we}, 1);
        wait_idle();
        hread(A_DATA, v); chk("R4 data kept", v, 32'hDEAD_BEEF);

        // R5 step-up sequence
        lat = 2;
        push(0, 16'h0010, 0, "R5 read0");
        hwrite(A_CMD, 32'hE000_0010);
        wait_idle();
        push(0, 16'h0011, 0, "R5 read1");
        hread(A_DATA, v); chk("R5 data0", v, f(16'h0010));
        chk("R5 restart", {31'd0, bank_req}, 1);
        wait_idle();
        push(0, 16'h0012, 0, "R5 read2");
        hread(A_DATA, v); chk("R5 data1", v, f(16'h0011));
        wait_idle();
        hwrite(A_CMD, 32'h4000_0012);
        hread(A_DATA, v); chk("R5 last data", v, f(16'h0012));
        chk("R5 no extra read", {31'd0, bank_req}, 0);

        // R6 / R8 step-down with wrap
        push(0, 16'h0001, 0, "R6 read0");
        hwrite(A_CMD, 32'hD000_0001);
        wait_idle();
        push(0, 16'h0000, 0, "R6 read1");
        hread(A_DATA, v); chk("R6 data0", v, f(16'h0001));
        wait_idle();
        push(0, 16'hFFFF, 0, "R8 read wrap down");
        hread(A_DATA, v); chk("R6 data1", v, f(16'h0000));
        wait_idle();
        hread(A_CMD, v); chk("R8 wrap down addr", v, 32'h5000_FFFF);
        hwrite(A_CMD, 32'h4000_FFFF);
        hread(A_DATA, v); chk("R6 last data", v, f(16'hFFFF));

        // R8 step-up wrap
        push(0, 16'hFFFF, 0, "R8 read top");
        hwrite(A_CMD, 32'hE000_FFFF);
        wait_idle();
        push(0, 16'h0000, 0, "R8 read wrap up");
        hread(A_DATA, v);
        wait_idle();
        hread(A_CMD, v); chk("R8 wrap up addr", v, 32'h6000_0000);
        hwrite(A_CMD, 32'h4000_0000);
        hread(A_DATA, v); chk("R8 wrapped data", v, f(16'h0000));

        // R7 both step bits
        push(0, 16'h0020, 0, "R7 read");
        hwrite(A_CMD, 32'hF000_0020);
        wait_idle();
        hread(A_DATA, v); chk("R7 data", v, f(16'h0020));
        chk("R7 no restart", {31'd0, bank_req}, 0);
        hread(A_CMD, v); chk("R7 addr held", v, 32'h7000_0020);
        hwrite(A_CMD, 32'h0000_0000);

        // R9 direct window write
        push(1, 16'h01A5, 32'h0BAD_F00D, "R9 window write");
        hwrite(10'h3A5, 32'h0BAD_F00D);
        chk("R9 busy", {30'd0, bank_req, bank_we}, 3);
        wait_idle();
        hread(A_CMD, v);  chk("R9 cmd", v, 32'h0000_01A5);
        hread(A_DATA, v); chk("R9 data", v, 32'h0BAD_F00D);

        // R10 writes while busy
        lat = 8;
        push(0, 16'h0040, 0, "R10 read");
        hwrite(A_CMD, 32'hC000_0040);
        hwrite(A_DATA, 32'h0000_1111);
        hwrite(A_CMD, 32'hC000_0099);
        wait_idle();
        hread(A_CMD, v);  chk("R10 err set, cmd ignored", v, 32'h4800_0040);
        hread(A_DATA, v); chk("R10 data ignored", v, f(16'h0040));
        hwrite(A_CMD, 32'h0800_0000);
        hread(A_CMD, v);  chk("R10 err cleared", v, 32'h0000_0000);

        // R11 data read while busy
        push(0, 16'h0030, 0, "R11 read");
        hwrite(A_CMD, 32'hE000_0030);
        hread(A_DATA, v);
        wait_idle();
        hread(A_CMD, v); chk("R11 no step", v, 32'h6000_0030);
        hwrite(A_CMD, 32'h4000_0030);

        // R10 write in the acknowledge cycle
        lat = 4;
        hwrite(A_DATA, 32'h7777_0000);
        push(1, 16'h0050, 32'h7777_0000, "R10 ack-cycle write");
        hwrite(A_CMD, 32'h8000_0050);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            #1;
            if (bank_ack) break;
        end
        host_wr = 1; host_addr = A_DATA; host_wdata = 32'h0000_2222;
        @(negedge clk);
        host_wr = 0;
        wait_idle();
        hread(A_CMD, v);  chk("R10 ack-cycle err", v, 32'h0800_0050);
        hread(A_DATA, v); chk("R10 ack-cycle data", v, 32'h7777_0000);
        hwrite(A_CMD, 32'h0800_0000);

        repeat (4) @(negedge clk);
        chk("R3 scoreboard drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule